// File: doc/BRIEF.md
# Electrical Fuse Array Controller

This block controls a one-time-programmable fuse array of 8 banks with 256 byte-wide words each. The array is modelled behaviourally inside the block. A simple single-cycle register bus reaches two areas. The first is a small register file holding status, error flags, two mask registers, control, a split fuse address, captured sense data and a program key. The second is a shadow window that holds one byte per fuse word. Software can read and override these bytes, and they are kept apart from the physical fuses.

Software first sets the fuse address and then starts one of two operations. An explicit sense copies the addressed physical word into the sense-data register. A program cycle blows one addressed bit, and it runs only while the key register holds the unlock value. Each operation keeps the busy flag high for a fixed, parameterised number of clocks and then sets its done flag.

Access rights are set per bank by three lock inputs, and they apply to every word of that bank. The read lock guards shadow reads, the override lock guards shadow writes, and the write lock guards fuse programming. Every refused access raises its own error flag.

Top module: `efuse_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and every fuse and shadow byte is 0. Register offsets on the bus are: 0 status, 1 status mask, 2 error, 3 error mask, 4 control, 5 upper address, 6 lower address, 7 sense data, 8 program key. Address bit 11 set selects the shadow window at index bank*256+word.
- R2: Status bit 7 reads 1 for exactly CYCLES clocks after a start is accepted. When the cycle ends, bit 1 (program done) or bit 0 (sense done) sets. Writing 1 to a status bit clears it.
- R3: A write of control bit 0 while the key register is not 0xAA sets error bit 7. It starts no cycle and leaves the array unchanged.
- R4: An accepted program cycle sets exactly one fuse bit. Its bank is upper-address bits 5:3, its row is {upper bits 2:0, lower bits 7:3}, and its bit is lower bits 2:0. Control reads 0 once the cycle has finished.
- R5: A sense cycle (control bit 3) loads the addressed physical fuse word into the sense-data register.
- R6: A program start on a bank whose write lock is high sets error bit 6. It starts no cycle, leaves program done clear and leaves the fuse unchanged.
- R7: A control write issued while busy is ignored.
- R8: A shadow write to an unlocked bank is read back unchanged. Shadow contents and physical fuses do not affect each other.
- R9: A shadow write to a bank whose override lock is high leaves the word unchanged and sets error bit 5.
- R10: A shadow read from a bank whose read lock is high returns 0x00 and sets error bit 4.
- R11: Writing 1 to an error bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register offset or shadow window address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Pulses one cycle after a read request |
| lock_rd | input | 8 | Per-bank shadow read lock |
| lock_ov | input | 8 | Per-bank shadow override lock |
| lock_wr | input | 8 | Per-bank program lock |

## Verification
The bench samples status on every cycle of a program cycle. A timer that is off by one would show busy one cycle too long or too short, or would set the done flag early. Two bits are burned into the same word, and a sense must then return both of them. A design that overwrote the word instead of OR-ing in the new bit would lose the first bit. A program request issued while a sense is in flight must leave the fuses unchanged and program done clear. Locked and unlocked banks are mixed so that a lock decoded against the wrong bank either blocks a legal access or lets a refused one through, and either way changes the data or the error flags that are read back.

// File: rtl/efuse_pkg.sv
package efuse_pkg;
    localparam int ST_BUSY  = 7;
    localparam int ST_PDONE = 1;
    localparam int ST_SDONE = 0;

    localparam int ER_PROG  = 7;
    localparam int ER_WPROT = 6;
    localparam int ER_OPROT = 5;
    localparam int ER_RPROT = 4;

    localparam int CT_PROG  = 0;
    localparam int CT_SENSE = 3;

    localparam logic [7:0] UNLOCK_KEY = 8'hAA;

    typedef enum logic [3:0] {
        RA_STAT  = 4'd0,
        RA_STATM = 4'd1,
        RA_ERR   = 4'd2,
        RA_ERRM  = 4'd3,
        RA_CTRL  = 4'd4,
        RA_ADRH  = 4'd5,
        RA_ADRL  = 4'd6,
        RA_SDAT  = 4'd7,
        RA_KEY   = 4'd8
    } reg_e;
endpackage

// File: rtl/efuse_mem.sv
module efuse_mem #(
    parameter int DEPTH = 2048,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/efuse_timer.sv
module efuse_timer #(
    parameter int CYCLES = 4,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic          busy_d, busy_q;
    logic [CW-1:0] cnt_d, cnt_q;

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == CW'(CYCLES - 1));

    always_comb begin
        busy_d = busy_q;
        cnt_d  = cnt_q;
        if (start && !busy_q) begin
            busy_d = 1'b1;
            cnt_d  = '0;
        end else if (done) begin
            busy_d = 1'b0;
            cnt_d  = '0;
        end else if (busy_q) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            busy_q <= busy_d;
            cnt_q  <= cnt_d;
        end
    end

    // R2: the counter never runs past the cycle length
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < CW'(CYCLES)));
    // R2: busy drops right after the final cycle
    p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy_q);
endmodule

// File: rtl/efuse_ctrl.sv
module efuse_ctrl
    import efuse_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int NWORD  = 256,
    parameter int CYCLES = 4,
    localparam int IW    = $clog2(NBANK * NWORD),
    localparam int BW    = $clog2(NBANK),
    localparam int RW    = $clog2(NWORD),
    localparam int AW    = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             bus_rvalid,
    input  logic [NBANK-1:0] lock_rd,
    input  logic [NBANK-1:0] lock_ov,
    input  logic [NBANK-1:0] lock_wr
);
    typedef struct packed {
        logic [7:0]    stat;
        logic [7:0]    statm;
        logic [7:0]    err;
        logic [7:0]    errm;
        logic [7:0]    ctrl;
        logic [7:0]    adrh;
        logic [7:0]    adrl;
        logic [7:0]    sdat;
        logic [7:0]    key;
        logic [7:0]    rdata;
        logic          rvalid;
        logic          op_prog;
        logic [IW-1:0] cyc_idx;
        logic [2:0]    cyc_bit;
    } st_t;

    st_t d, q;

    logic          t_start, t_busy, t_done;
    logic          fuse_we, shadow_we;
    logic [7:0]    fuse_wdata, fuse_rd, shadow_rd;
    logic [IW-1:0] win_idx, cur_idx;
    logic [BW-1:0] win_bank, cur_bank;
    logic          win_sel, wr_req, rd_req;

    assign wr_req   = bus_sel && bus_wr;
    assign rd_req   = bus_sel && !bus_wr;
    assign win_sel  = bus_addr[AW-1];
    assign win_idx  = bus_addr[IW-1:0];
    assign win_bank = BW'(win_idx >> RW);
    assign cur_bank = BW'(q.adrh[5:3]);
    assign cur_idx  = IW'(int'(q.adrh[5:3]) * NWORD + int'({q.adrh[2:0], q.adrl[7:3]}));

    efuse_timer #(.CYCLES(CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(t_start), .busy(t_busy), .done(t_done)
    );

    efuse_mem #(.DEPTH(NBANK * NWORD), .W(8)) u_fuse (
        .clk(clk), .rst_n(rst_n), .we(fuse_we), .waddr(q.cyc_idx),
        .wdata(fuse_wdata), .raddr(q.cyc_idx), .rdata(fuse_rd)
    );

    efuse_mem #(.DEPTH(NBANK * NWORD), .W(8)) u_shadow (
        .clk(clk), .rst_n(rst_n), .we(shadow_we), .waddr(win_idx),
        .wdata(bus_wdata), .raddr(win_idx), .rdata(shadow_rd)
    );

    assign fuse_wdata = fuse_rd | (8'd1 << q.cyc_bit);

    always_comb begin
        d         = q;
        d.rvalid  = 1'b0;
        t_start   = 1'b0;
        shadow_we = 1'b0;
        fuse_we   = 1'b0;

        if (wr_req) begin
            if (win_sel) begin
                if (lock_ov[win_bank]) d.err[ER_OPROT] = 1'b1;
                else                   shadow_we = 1'b1;
            end else begin
                case (reg_e'(bus_addr[3:0]))
                    RA_STAT:  d.stat  = q.stat & ~bus_wdata;
                    RA_STATM: d.statm = bus_wdata;
                    RA_ERR:   d.err   = q.err & ~bus_wdata;
                    RA_ERRM:  d.errm  = bus_wdata;
                    RA_ADRH:  d.adrh  = bus_wdata;
                    RA_ADRL:  d.adrl  = bus_wdata;
                    RA_KEY:   d.key   = bus_wdata;
                    RA_CTRL: begin
                        if (!t_busy) begin
                            if (bus_wdata[CT_PROG]) begin
                                if (q.key != UNLOCK_KEY) begin
                                    d.err[ER_PROG] = 1'b1;
                                end else if (lock_wr[cur_bank]) begin
                                    d.err[ER_WPROT] = 1'b1;
                                end else begin
                                    t_start   = 1'b1;
                                    d.op_prog = 1'b1;
                                    d.ctrl    = 8'h01;
                                    d.cyc_idx = cur_idx;
                                    d.cyc_bit = q.adrl[2:0];
                                end
                            end else if (bus_wdata[CT_SENSE]) begin
                                t_start   = 1'b1;
                                d.op_prog = 1'b0;
                                d.ctrl    = 8'h08;
                                d.cyc_idx = cur_idx;
                                d.cyc_bit = q.adrl[2:0];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end

        if (rd_req) begin
            d.rvalid = 1'b1;
            if (win_sel) begin
                if (lock_rd[win_bank]) begin
                    d.rdata          = 8'h00;
                    d.err[ER_RPROT]  = 1'b1;
                end else begin
                    d.rdata = shadow_rd;
                end
            end else begin
                case (reg_e'(bus_addr[3:0]))
                    RA_STAT:  d.rdata = q.stat | {t_busy, 7'b0};
                    RA_STATM: d.rdata = q.statm;
                    RA_ERR:   d.rdata = q.err;
                    RA_ERRM:  d.rdata = q.errm;
                    RA_CTRL:  d.rdata = q.ctrl;
                    RA_ADRH:  d.rdata = q.adrh;
                    RA_ADRL:  d.rdata = q.adrl;
                    RA_SDAT:  d.rdata = q.sdat;
                    RA_KEY:   d.rdata = q.key;
                    default:  d.rdata = 8'h00;
                endcase
            end
        end

        if (t_done) begin
            d.ctrl = 8'h00;
            if (q.op_prog) begin
                fuse_we           = 1'b1;
                d.stat[ST_PDONE]  = 1'b1;
            end else begin
                d.sdat            = fuse_rd;
                d.stat[ST_SDONE]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata  = q.rdata;
    assign bus_rvalid = q.rvalid;

    // R3: a program cycle only begins with the key present
    p_key_before_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(t_busy) && q.op_prog) |-> ($past(q.key) == UNLOCK_KEY));
    // R2: program done only rises at the end of a busy period
    p_pdone_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.stat[ST_PDONE]) |-> $past(t_busy));
    // R4: start bits are clear whenever no cycle runs
    p_ctrl_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !t_busy |-> (q.ctrl == 8'h00));
endmodule

// File: tb/tb_efuse_ctrl.sv
module tb_efuse_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  lock_rd = 8'h20, lock_ov = 8'h10, lock_wr = 8'h08;

    int checks = 0, errors = 0;
    bit ended = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    efuse_ctrl #(.NBANK(8), .NWORD(256), .CYCLES(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .lock_rd(lock_rd), .lock_ov(lock_ov), .lock_wr(lock_wr)
    );

    // monitor: compare each returned read with the queued expectation
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read data actual=%02h expected=none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual=%02h expected=%02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [7:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (CYC + 3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h000, 8'h00, "R1 status");
        rd(12'h002, 8'h00, "R1 error");
        rd(12'h004, 8'h00, "R1 control");
        rd(12'h008, 8'h00, "R1 key");
        rd(12'h007, 8'h00, "R1 sense data");

        // R3 program without key: bank 2 row 0x25 bit 5
        wr(12'h005, 8'h11);
        wr(12'h006, 8'h2D);
        wr(12'h004, 8'h01);
        settle();
        rd(12'h002, 8'h80, "R3 program error flag");
        rd(12'h000, 8'h00, "R3 no cycle ran");
        wr(12'h002, 8'h80);
        rd(12'h002, 8'h00, "R11 error cleared");

        // R2 busy length and program done
        wr(12'h008, 8'hAA);
        wr(12'h004, 8'h01);
        for (int i = 0; i < CYC; i++) rd(12'h000, 8'h80, "R2 busy during cycle");
        rd(12'h000, 8'h02, "R2 program done after cycle");
        rd(12'h004, 8'h00, "R4 control self-cleared");
        wr(12'h000, 8'h02);
        rd(12'h000, 8'h00, "R2 status cleared");

        // R4 second bit in same word, then R5 sense
        wr(12'h006, 8'h28);
        wr(12'h004, 8'h01);
        settle();
        wr(12'h004, 8'h08);
        settle();
        rd(12'h007, 8'h21, "R5 sense data two bits");
        rd(12'h000, 8'h03, "R5 both done flags");
        wr(12'h000, 8'h03);

        // R7 program request during sense is ignored
        wr(12'h004, 8'h08);
        wr(12'h006, 8'h2F);
        wr(12'h004, 8'h01);
        settle();
        rd(12'h000, 8'h01, "R7 only sense done");
        rd(12'h002, 8'h00, "R7 no error");
        wr(12'h000, 8'h01);
        wr(12'h004, 8'h08);
        settle();
        rd(12'h007, 8'h21, "R7 fuse unchanged");
        wr(12'h000, 8'h01);

        // R6 write-locked bank 3
        wr(12'h005, 8'h19);
        wr(12'h006, 8'h2D);
        wr(12'h004, 8'h01);
        settle();
        rd(12'h002, 8'h40, "R6 write protect error");
        rd(12'h000, 8'h00, "R6 program done clear");
        wr(12'h002, 8'h40);
        wr(12'h004, 8'h08);
        settle();
        rd(12'h007, 8'h00, "R6 locked fuse unchanged");
        wr(12'h000, 8'h01);

        // R8 shadow override, independent of fuses
        wr(12'h907, 8'h5A);
        rd(12'h907, 8'h5A, "R8 shadow readback");
        rd(12'hA25, 8'h00, "R8 shadow unaffected by fuses");
        wr(12'h005, 8'h08);
        wr(12'h006, 8'h38);
        wr(12'h004, 8'h08);
        settle();
        rd(12'h007, 8'h00, "R8 fuse unaffected by shadow");
        rd(12'h002, 8'h00, "R8 no error");

        // R9 override-locked bank 4
        wr(12'hC03, 8'h77);
        rd(12'h002, 8'h20, "R9 override protect error");
        rd(12'hC03, 8'h00, "R9 word unchanged");
        wr(12'h002, 8'h20);

        // R10 read-locked bank 5
        wr(12'hD09, 8'h33);
        rd(12'h002, 8'h00, "R10 write allowed");
        rd(12'hD09, 8'h00, "R10 read returns zero");
        rd(12'h002, 8'h10, "R10 read protect error");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule